// File: doc/BRIEF.md
# Translation root pointer cache

This block hands the page-table root pointer to a radix address translation unit. A lookup carries an effective address; its most significant bit picks one of two cached process-table entries. One is the entry at index 0 and the other is the entry indexed by the current process ID. The chosen root pointer comes back with a one-cycle valid pulse. The process-table base itself comes from a one-entry partition table, and that entry is cached too. A write to the alternate base register can also load it directly.

On a miss the block issues single doubleword reads, one at a time. It first refills the partition entry if that entry is not held. It then reads the first doubleword of the 16-byte process-table entry. The partition-control, base and process-ID registers each clear a different set of cached entries. An invalidate command whose type field equals 2 clears both process-table entries. A fetch that overlaps any of these events is thrown away and run again.

Top module: `root_ptr_cache`

## Requirements
- R1: After reset, rdy_o is 1 and resp_valid_o, mem_req_o and tlb_flush_o are 0.
- R2: The first lookup after a partition-control write with value P issues two reads, the first at address P+8. rdy_o is low from acceptance until the response. resp_valid_o is high for exactly one cycle.
- R3: When req_ea_i[63]=1, the root is the doubleword at address B. When req_ea_i[63]=0, it is the doubleword at B + (PID << 4). B is the process-table base and PID is the process-ID register.
- R4: A lookup whose entry is cached issues no read. resp_valid_o is high in the second cycle after the request is accepted.
- R5: An invalidate with inval_ric_i=2 clears both process-table entries and keeps the partition entry, so the next lookup issues one read. Any other inval_ric_i value has no effect.
- R6: A process-ID write clears only the PID-indexed entry. The index-0 entry stays cached.
- R7: A write to the base register makes its value the process-table base without a partition read, and it clears both process-table entries.
- R8: A partition-control write clears the partition entry and both process-table entries.
- R9: tlb_flush_o is high for exactly the one cycle after each partition-control, base or process-ID write. Invalidate commands never raise it.
- R10: Suppose one of the events in R5 to R8 occurs while a read is outstanding. The returned data is discarded, and the fetch is redone using the updated state.
- R11: mem_req_o is a one-cycle pulse per read and never stays high for two cycles in a row.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| ptcr_we_i | input | 1 | Partition-control register write strobe |
| ptcr_wdata_i | input | 64 | Partition-control register write value |
| base_we_i | input | 1 | Alternate process-table base write strobe |
| base_wdata_i | input | 64 | Alternate process-table base value |
| pid_we_i | input | 1 | Process-ID register write strobe |
| pid_wdata_i | input | 20 | Process-ID value |
| inval_i | input | 1 | Invalidate command strobe |
| inval_ric_i | input | 2 | Invalidate type; 2 clears the process-table entries |
| req_i | input | 1 | Lookup request, taken when rdy_o is 1 |
| req_ea_i | input | 64 | Effective address; bit 63 selects the entry |
| rdy_o | output | 1 | Ready to accept a lookup |
| resp_valid_o | output | 1 | Root pointer valid pulse |
| resp_root_o | output | 64 | Root pointer |
| mem_req_o | output | 1 | Doubleword read request pulse |
| mem_addr_o | output | 64 | Read address |
| mem_rvalid_i | input | 1 | Read data valid |
| mem_rdata_i | input | 64 | Read data |
| tlb_flush_o | output | 1 | Flush pulse to the instruction and data TLBs |

## Verification
A table of lookups, register writes and invalidates runs with both values of the top address bit. It tells the entry-0 slot apart from the PID-indexed slot, because their contents come from different addresses. For every lookup, the bench checks the read count and the hit latency. These counts separate a full miss (partition read plus entry read), a partial miss (entry read only) and a hit. This in turn shows which cached entries each register write or invalidate type left in place. A directed case changes the process ID while a slow read is outstanding. That case tells a restarted fetch apart from one that kept stale data.

// File: rtl/rpc_pkg.sv
package rpc_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_CHECK,
    ST_WAIT_PART,
    ST_WAIT_PTE
  } rpc_state_e;

  localparam int SLOT_PART = 0;
  localparam int SLOT_PID  = 1;
  localparam int SLOT_ZERO = 2;
  localparam int NSLOT     = 3;
endpackage

// File: rtl/rpc_slot.sv
module rpc_slot #(
  parameter int W = 64
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         clr_i,
  input  logic         set_i,
  input  logic [W-1:0] data_i,
  output logic         vld_o,
  output logic [W-1:0] data_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      vld_o  <= 1'b0;
      data_o <= '0;
    end else if (clr_i) begin
      vld_o  <= 1'b0;
    end else if (set_i) begin
      vld_o  <= 1'b1;
      data_o <= data_i;
    end
  end
endmodule

// File: rtl/rpc_addr.sv
module rpc_addr #(
  parameter int AW        = 64,
  parameter int PID_W     = 20,
  parameter int PTE_SHIFT = 4,
  parameter int PART_OFS  = 8
) (
  input  logic [AW-1:0]    ptcr_i,
  input  logic [AW-1:0]    base_i,
  input  logic [PID_W-1:0] pid_i,
  input  logic             part_i,
  input  logic             sel_i,
  output logic [AW-1:0]    addr_o
);
  localparam int PAD = AW - PID_W - PTE_SHIFT;

  logic [AW-1:0] pid_off;
  assign pid_off = {{PAD{1'b0}}, pid_i, {PTE_SHIFT{1'b0}}};

  always_comb begin
    if (part_i)     addr_o = ptcr_i + AW'(PART_OFS);
    else if (sel_i) addr_o = base_i;
    else            addr_o = base_i + pid_off;
  end
endmodule

// File: rtl/rpc_ctrl.sv
module rpc_ctrl
  import rpc_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic req_i,
  input  logic sel_i,
  input  logic part_vld_i,
  input  logic pid_vld_i,
  input  logic zero_vld_i,
  input  logic inv_i,
  input  logic mem_rvalid_i,
  output logic rdy_o,
  output logic mem_req_o,
  output logic sel_o,
  output logic hit_o,
  output logic fill_part_o,
  output logic fill_pid_o,
  output logic fill_zero_o
);
  rpc_state_e state_q, state_d;
  logic sel_q, stale_q, drop, slot_hit, waiting_d;

  assign sel_o     = sel_q;
  assign slot_hit  = sel_q ? zero_vld_i : pid_vld_i;
  assign drop      = stale_q | inv_i;
  assign waiting_d = (state_d == ST_WAIT_PART) || (state_d == ST_WAIT_PTE);

  always_comb begin
    state_d     = state_q;
    rdy_o       = 1'b0;
    mem_req_o   = 1'b0;
    hit_o       = 1'b0;
    fill_part_o = 1'b0;
    fill_pid_o  = 1'b0;
    fill_zero_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        rdy_o = 1'b1;
        if (req_i) state_d = ST_CHECK;
      end
      ST_CHECK: begin
        if (slot_hit) begin
          hit_o   = 1'b1;
          state_d = ST_IDLE;
        end else begin
          mem_req_o = 1'b1;
          state_d   = part_vld_i ? ST_WAIT_PTE : ST_WAIT_PART;
        end
      end
      ST_WAIT_PART: begin
        if (mem_rvalid_i) begin
          fill_part_o = !drop;
          state_d     = ST_CHECK;
        end
      end
      ST_WAIT_PTE: begin
        if (mem_rvalid_i) begin
          fill_pid_o  = !drop && !sel_q;
          fill_zero_o = !drop && sel_q;
          state_d     = ST_CHECK;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      sel_q   <= 1'b0;
      stale_q <= 1'b0;
    end else begin
      state_q <= state_d;
      stale_q <= waiting_d & (stale_q | inv_i);
      if (state_q == ST_IDLE && req_i) sel_q <= sel_i;
    end
  end
endmodule

// File: rtl/root_ptr_cache.sv
module root_ptr_cache
  import rpc_pkg::*;
#(
  parameter int AW        = 64,
  parameter int PID_W     = 20,
  parameter int PTE_SHIFT = 4,
  parameter int PART_OFS  = 8,
  parameter int RIC_W     = 2,
  parameter int RIC_ALL   = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ptcr_we_i,
  input  logic [AW-1:0]    ptcr_wdata_i,
  input  logic             base_we_i,
  input  logic [AW-1:0]    base_wdata_i,
  input  logic             pid_we_i,
  input  logic [PID_W-1:0] pid_wdata_i,
  input  logic             inval_i,
  input  logic [RIC_W-1:0] inval_ric_i,
  input  logic             req_i,
  input  logic [AW-1:0]    req_ea_i,
  output logic             rdy_o,
  output logic             resp_valid_o,
  output logic [AW-1:0]    resp_root_o,
  output logic             mem_req_o,
  output logic [AW-1:0]    mem_addr_o,
  input  logic             mem_rvalid_i,
  input  logic [AW-1:0]    mem_rdata_i,
  output logic             tlb_flush_o
);
  logic [AW-1:0]    ptcr_q;
  logic [PID_W-1:0] pid_q;
  logic             flush_q;
  logic             ric_all, any_inv, sel, hit;
  logic             fill_part, fill_pid, fill_zero;
  logic [NSLOT-1:0] slot_clr, slot_set, slot_vld;
  logic [AW-1:0]    slot_din  [NSLOT];
  logic [AW-1:0]    slot_dout [NSLOT];
  logic             unused_ea;

  assign unused_ea = ^req_ea_i[AW-2:0];
  assign ric_all   = inval_i && (inval_ric_i == RIC_W'(RIC_ALL));
  assign any_inv   = ptcr_we_i | base_we_i | pid_we_i | ric_all;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptcr_q  <= '0;
      pid_q   <= '0;
      flush_q <= 1'b0;
    end else begin
      flush_q <= ptcr_we_i | base_we_i | pid_we_i;
      if (ptcr_we_i) ptcr_q <= ptcr_wdata_i;
      if (pid_we_i)  pid_q  <= pid_wdata_i;
    end
  end
  assign tlb_flush_o = flush_q;

  // per-slot clear rules; clear dominates set
  assign slot_clr[SLOT_PART] = ptcr_we_i;
  assign slot_set[SLOT_PART] = base_we_i | fill_part;
  assign slot_din[SLOT_PART] = base_we_i ? base_wdata_i : mem_rdata_i;
  assign slot_clr[SLOT_PID]  = ptcr_we_i | base_we_i | pid_we_i | ric_all;
  assign slot_set[SLOT_PID]  = fill_pid;
  assign slot_din[SLOT_PID]  = mem_rdata_i;
  assign slot_clr[SLOT_ZERO] = ptcr_we_i | base_we_i | ric_all;
  assign slot_set[SLOT_ZERO] = fill_zero;
  assign slot_din[SLOT_ZERO] = mem_rdata_i;

  for (genvar g = 0; g < NSLOT; g++) begin : g_slot
    rpc_slot #(.W(AW)) u_slot (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .clr_i  (slot_clr[g]),
      .set_i  (slot_set[g]),
      .data_i (slot_din[g]),
      .vld_o  (slot_vld[g]),
      .data_o (slot_dout[g])
    );
  end

  rpc_ctrl u_ctrl (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .req_i        (req_i),
    .sel_i        (req_ea_i[AW-1]),
    .part_vld_i   (slot_vld[SLOT_PART]),
    .pid_vld_i    (slot_vld[SLOT_PID]),
    .zero_vld_i   (slot_vld[SLOT_ZERO]),
    .inv_i        (any_inv),
    .mem_rvalid_i (mem_rvalid_i),
    .rdy_o        (rdy_o),
    .mem_req_o    (mem_req_o),
    .sel_o        (sel),
    .hit_o        (hit),
    .fill_part_o  (fill_part),
    .fill_pid_o   (fill_pid),
    .fill_zero_o  (fill_zero)
  );

  rpc_addr #(
    .AW(AW), .PID_W(PID_W), .PTE_SHIFT(PTE_SHIFT), .PART_OFS(PART_OFS)
  ) u_addr (
    .ptcr_i (ptcr_q),
    .base_i (slot_dout[SLOT_PART]),
    .pid_i  (pid_q),
    .part_i (!slot_vld[SLOT_PART]),
    .sel_i  (sel),
    .addr_o (mem_addr_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      resp_valid_o <= 1'b0;
      resp_root_o  <= '0;
    end else begin
      resp_valid_o <= hit;
      if (hit) resp_root_o <= sel ? slot_dout[SLOT_ZERO] : slot_dout[SLOT_PID];
    end
  end
endmodule

// File: rtl/rpc_chk.sv
module rpc_chk #(
  parameter int RIC_W = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             ptcr_we_i,
  input logic             base_we_i,
  input logic             pid_we_i,
  input logic             inval_i,
  input logic [RIC_W-1:0] inval_ric_i,
  input logic             rdy_o,
  input logic             resp_valid_o,
  input logic             mem_req_o,
  input logic             tlb_flush_o,
  input logic [2:0]       slot_vld
);
  logic wr_any, ric2;
  assign wr_any = ptcr_we_i | base_we_i | pid_we_i;
  assign ric2   = inval_i && (inval_ric_i == RIC_W'(2));

  AST_RESP_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resp_valid_o |=> !resp_valid_o); // R2
  AST_BUSY_ON_READ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> !rdy_o); // R2
  AST_MEM_REQ_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |=> !mem_req_o); // R11
  AST_FLUSH_AFTER_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_any |=> tlb_flush_o); // R9
  AST_FLUSH_ONLY_ON_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_any |=> !tlb_flush_o); // R9
  AST_RIC2_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ric2 |=> (slot_vld[2:1] == 2'b00)); // R5
  AST_PID_KEEPS_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pid_we_i && !ptcr_we_i && !base_we_i && !ric2 && slot_vld[2]) |=> slot_vld[2]); // R6
  AST_PTCR_CLEARS_ALL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptcr_we_i |=> (slot_vld == 3'b000)); // R8
endmodule

bind root_ptr_cache rpc_chk #(.RIC_W(RIC_W)) u_chk (
  .clk_i        (clk_i),
  .rst_ni       (rst_ni),
  .ptcr_we_i    (ptcr_we_i),
  .base_we_i    (base_we_i),
  .pid_we_i     (pid_we_i),
  .inval_i      (inval_i),
  .inval_ric_i  (inval_ric_i),
  .rdy_o        (rdy_o),
  .resp_valid_o (resp_valid_o),
  .mem_req_o    (mem_req_o),
  .tlb_flush_o  (tlb_flush_o),
  .slot_vld     (slot_vld)
);

// File: tb/root_ptr_cache_tb.sv
module root_ptr_cache_tb;
  localparam logic [2:0] OP_LOOK = 3'd0, OP_PID = 3'd1, OP_PTCR = 3'd2,
                         OP_BASE = 3'd3, OP_INV = 3'd4;
  typedef struct packed {
    logic [2:0]  op;
    logic [63:0] val;   // lookup: bit0 = ea[63]; inv: ric
    logic [1:0]  rd;    // expected reads for a lookup
    logic [3:0]  req;
  } vec_t;
  localparam int NV = 19;
  localparam vec_t VECS [NV] = '{
    '{OP_PTCR, 64'h8000,  2'd0, 4'd9},  // R9
    '{OP_LOOK, 64'd0,     2'd2, 4'd2},  // R2 full miss, R3 pid slot
    '{OP_LOOK, 64'd0,     2'd0, 4'd4},  // R4 hit
    '{OP_LOOK, 64'd1,     2'd1, 4'd3},  // R3 entry 0
    '{OP_LOOK, 64'd1,     2'd0, 4'd4},
    '{OP_PID,  64'd5,     2'd0, 4'd9},
    '{OP_LOOK, 64'd1,     2'd0, 4'd6},  // R6 entry 0 kept
    '{OP_LOOK, 64'd0,     2'd1, 4'd6},  // R6 pid slot refetched
    '{OP_INV,  64'd1,     2'd0, 4'd9},
    '{OP_LOOK, 64'd0,     2'd0, 4'd5},  // R5 ric 1 no effect
    '{OP_INV,  64'd2,     2'd0, 4'd9},
    '{OP_LOOK, 64'd1,     2'd1, 4'd5},  // R5 partition kept
    '{OP_LOOK, 64'd0,     2'd1, 4'd5},
    '{OP_BASE, 64'h20000, 2'd0, 4'd9},
    '{OP_LOOK, 64'd0,     2'd1, 4'd7},  // R7
    '{OP_LOOK, 64'd1,     2'd1, 4'd7},
    '{OP_PTCR, 64'h4000,  2'd0, 4'd9},
    '{OP_LOOK, 64'd1,     2'd2, 4'd8},  // R8
    '{OP_LOOK, 64'd0,     2'd1, 4'd8}
  };

  logic        clk = 1'b0, rst_n = 1'b0;
  logic        ptcr_we = 0, base_we = 0, pid_we = 0, inval = 0, req = 0;
  logic [63:0] ptcr_wd = '0, base_wd = '0, ea = '0;
  logic [19:0] pid_wd = '0;
  logic [1:0]  ric = '0;
  logic        rdy, resp_valid, mem_req, mem_rvalid = 0, flush;
  logic [63:0] resp_root, mem_addr, mem_rdata = '0;

  int errors = 0, checks = 0, rd_cnt = 0, dbl = 0, mem_lat = 2, cnt = 0;
  logic [63:0] addr_l = '0;
  logic        prev_req = 0;
  logic [63:0] base_m = '0;
  logic [19:0] pid_m = '0;

  always #5 clk = ~clk;

  root_ptr_cache u_dut (
    .clk_i(clk), .rst_ni(rst_n),
    .ptcr_we_i(ptcr_we), .ptcr_wdata_i(ptcr_wd),
    .base_we_i(base_we), .base_wdata_i(base_wd),
    .pid_we_i(pid_we), .pid_wdata_i(pid_wd),
    .inval_i(inval), .inval_ric_i(ric),
    .req_i(req), .req_ea_i(ea),
    .rdy_o(rdy), .resp_valid_o(resp_valid), .resp_root_o(resp_root),
    .mem_req_o(mem_req), .mem_addr_o(mem_addr),
    .mem_rvalid_i(mem_rvalid), .mem_rdata_i(mem_rdata),
    .tlb_flush_o(flush)
  );

  function automatic logic [63:0] mem_f(input logic [63:0] a);
    return {a[47:0], 16'h0} ^ 64'h0123_4567_89AB_CDEF;
  endfunction

  function automatic logic [63:0] exp_root(input logic hi);
    return hi ? mem_f(base_m) : mem_f(base_m + {40'd0, pid_m, 4'd0});
  endfunction

  // memory model: one outstanding read, fixed latency
  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    prev_req   <= mem_req;
    if (mem_req && prev_req) dbl <= dbl + 1;
    if (cnt > 0) begin
      cnt <= cnt - 1;
      if (cnt == 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= mem_f(addr_l);
      end
    end
    if (mem_req) begin
      addr_l <= mem_addr;
      cnt    <= mem_lat;
      rd_cnt <= rd_cnt + 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [2:0] op, input logic [63:0] val, input string tag);
    @(negedge clk);
    case (op)
      OP_PTCR: begin ptcr_we = 1; ptcr_wd = val; base_m = mem_f(val + 64'd8); end
      OP_BASE: begin base_we = 1; base_wd = val; base_m = val; end
      OP_PID:  begin pid_we = 1; pid_wd = val[19:0]; pid_m = val[19:0]; end
      default: begin inval = 1; ric = val[1:0]; end
    endcase
    @(negedge clk);
    ptcr_we = 0; base_we = 0; pid_we = 0; inval = 0;
    chk(flush == (op != OP_INV), tag, 64'(flush), 64'(op != OP_INV));  // R9
    @(negedge clk);
    chk(flush == 1'b0, tag, 64'(flush), 64'd0);  // R9 single cycle
  endtask

  task automatic lookup(input logic hi, output logic [63:0] root, output int nrd,
                        output int lat, output bit busy);
    int r0;
    r0 = rd_cnt;
    @(negedge clk);
    req = 1; ea = {hi, 63'h0000_0000_0BAD_F00D};
    @(negedge clk);
    req = 0; busy = !rdy; lat = 1;
    while (!resp_valid && lat < 300) begin
      @(negedge clk);
      lat++;
    end
    root = resp_root;
    nrd  = rd_cnt - r0;
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("Result: errors=%0d of %0d checks", errors, checks + 1);
    $finish;
  end

  initial begin : main
    logic [63:0] root;
    int nrd, lat;
    bit busy;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(rdy && !resp_valid && !mem_req && !flush, "R1 in reset",
        {60'd0, rdy, resp_valid, mem_req, flush}, 64'h8);
    rst_n = 1;
    @(negedge clk);
    chk(rdy && !resp_valid && !mem_req && !flush, "R1 after reset",
        {60'd0, rdy, resp_valid, mem_req, flush}, 64'h8);

    for (int i = 0; i < NV; i++) begin
      string tag;
      tag = $sformatf("R%0d vec%0d", VECS[i].req, i);
      if (VECS[i].op == OP_LOOK) begin
        lookup(VECS[i].val[0], root, nrd, lat, busy);
        chk(root == exp_root(VECS[i].val[0]), {tag, " root"}, root, exp_root(VECS[i].val[0]));
        chk(nrd == int'(VECS[i].rd), {tag, " reads"}, 64'(nrd), 64'(VECS[i].rd));
        chk(busy, {tag, " busy"}, 64'(busy), 64'd1);  // R2
        if (VECS[i].rd == 2'd0)
          chk(lat == 2, {tag, " hit latency R4"}, 64'(lat), 64'd2);
        @(negedge clk);
        chk(!resp_valid, {tag, " pulse R2"}, 64'(resp_valid), 64'd0);
      end else begin
        do_write(VECS[i].op, VECS[i].val, tag);
      end
    end

    // R10: process-ID change while the entry read is outstanding
    mem_lat = 6;
    do_write(OP_PID, 64'd3, "R10 setup");
    begin
      int r0;
      r0 = rd_cnt;
      @(negedge clk);
      req = 1; ea = 64'h0;
      @(negedge clk);
      req = 0;
      repeat (2) @(negedge clk);
      pid_we = 1; pid_wd = 20'd7; pid_m = 20'd7;
      @(negedge clk);
      pid_we = 0;
      lat = 0;
      while (!resp_valid && lat < 300) begin
        @(negedge clk);
        lat++;
      end
      chk(resp_root == exp_root(1'b0), "R10 root after restart", resp_root, exp_root(1'b0));
      chk(rd_cnt - r0 == 2, "R10 refetch count", 64'(rd_cnt - r0), 64'd2);
    end
    @(negedge clk);
    // R10: the restarted fill holds the new entry
    lookup(1'b0, root, nrd, lat, busy);
    chk(nrd == 0 && root == exp_root(1'b0), "R10 hit after restart", root, exp_root(1'b0));

    // R11 read pulses never two cycles long
    chk(dbl == 0, "R11 mem_req pulse width", 64'(dbl), 64'd0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule